// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block keeps one 64-bit register that places the memory-mapped PCIe configuration window in the physical address map. The register is decoded into an enable, a window base and a window size. The block also reports whether a probed 64-bit physical address falls inside the enabled window, and it gives the bounds of the low PCI memory hole that sits above the window. Software writes the register through a simple port with one enable per byte and reads it back unchanged on the same port.

The valid base bits depend on the selected window length: a smaller window may sit on a finer alignment. When the window is enabled, the PCI hole begins right after it; otherwise the hole begins at the reset base. A reserved length code does not stop the block. It raises an error flag and turns the window off.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register reads 0x0000_0000_B000_0000. The window is disabled, hit and the error flag are low, and the hole starts at 0xB000_0000.
- R2: A write changes only the register bytes whose byte enable is set. The read port always returns the stored 64-bit value, including bits that the decode ignores, and the value is unchanged when no write occurs.
- R3: Register bit 0 is the enable. Bits 2:1 select the length: 00 = 256 MB (0x1000_0000), 01 = 128 MB (0x0800_0000), 10 = 64 MB (0x0400_0000), 11 = reserved.
- R4: The window base is the register ANDed with a mask that depends on the length: bits 35:28 for 256 MB, bits 35:27 for 128 MB and bits 35:26 for 64 MB. All other register bits have no effect on the base.
- R5: When the window is enabled, hit is high exactly when base <= probe_addr < base + size. The hit is combinational in probe_addr.
- R6: When the enable bit is clear, hit stays low for every address.
- R7: The reserved length code sets the error flag, forces the window off and reports a size of 0, so no address hits.
- R8: The hole start is base + size when the window is enabled, and 0xB000_0000 when it is disabled, including the reserved-code case.
- R9: The hole end is always 0xFEBF_FFFF, one byte below the I/O APIC base.
- R10: A register write takes effect on the clock edge that samples it. Before that edge, the outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 8 | Byte enables for the write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Stored register value |
| probe_addr | input | 64 | Physical address to test against the window |
| win_en | output | 1 | Window enabled and the length code is valid |
| win_base | output | 64 | Decoded window base |
| win_size | output | 64 | Window size in bytes, 0 when the length code is reserved |
| hit | output | 1 | probe_addr lies inside the enabled window |
| len_err | output | 1 | The reserved length code is selected |
| hole_start | output | 64 | First byte of the low PCI hole |
| hole_end | output | 64 | Last byte of the low PCI hole |

## Verification
Several properties are checked by assertions on every cycle:
- A hit never occurs without the enable.
- The reserved code always leaves the window off with a size of 0.
- The decoded base never carries bits outside bits 35:26.
- Any hit lies between the base and the hole start.
- Byte 0 tracks writes, and the register holds its value between writes.

Other behaviour can only be shown by the bench's directed scenarios:
- The exact base mask for each length code.
- The hole start after enabling, disabling and the reserved code.
- Which bytes a partial write leaves alone.
- The cycle in which a write becomes visible.

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder #(
  parameter int          AW           = 64,
  parameter logic [63:0] RESET_BASE   = 64'h0000_0000_B000_0000,
  parameter logic [63:0] IOAPIC_BASE  = 64'h0000_0000_FEC0_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [7:0]    reg_be,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic [AW-1:0] probe_addr,
  output logic          win_en,
  output logic [AW-1:0] win_base,
  output logic [AW-1:0] win_size,
  output logic          hit,
  output logic          len_err,
  output logic [AW-1:0] hole_start,
  output logic [AW-1:0] hole_end
);
  localparam logic [AW-1:0] MASK_256 = AW'(64'h0000_000F_F000_0000);
  localparam logic [AW-1:0] MASK_128 = AW'(64'h0000_000F_F800_0000);
  localparam logic [AW-1:0] MASK_64  = AW'(64'h0000_000F_FC00_0000);

  logic [AW-1:0] bar_q;
  logic [AW-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bar_q <= AW'(RESET_BASE);
    else if (reg_wr)
      for (int b = 0; b < AW/8; b++)
        if (reg_be[b]) bar_q[b*8 +: 8] <= reg_wdata[b*8 +: 8];
  end

  always_comb begin
    len_err  = 1'b0;
    mask     = MASK_256;
    win_size = AW'(64'h1000_0000);
    case (bar_q[2:1])
      2'b00: ;
      2'b01: begin mask = MASK_128; win_size = AW'(64'h0800_0000); end
      2'b10: begin mask = MASK_64;  win_size = AW'(64'h0400_0000); end
      default: begin len_err = 1'b1; win_size = '0; end
    endcase
  end

  assign reg_rdata  = bar_q;
  assign win_en     = bar_q[0] && !len_err;
  assign win_base   = bar_q & mask;
  assign hit        = win_en && (probe_addr >= win_base) && (probe_addr < win_base + win_size);
  assign hole_start = win_en ? win_base + win_size : AW'(RESET_BASE);
  assign hole_end   = AW'(IOAPIC_BASE) - AW'(1);

  assert_hit_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> win_en);
  assert_rsvd_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> (!win_en && win_size == '0 && !hit));
  assert_base_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_base[25:0] == '0) && (win_base[AW-1:36] == '0));
  assert_hit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (probe_addr >= win_base && probe_addr < hole_start));
  assert_byte0_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_be[0]) |=> reg_rdata[7:0] == $past(reg_wdata[7:0]));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(reg_rdata));
endmodule

// File: tb/sim_cfgwin_decoder.sv
module sim_cfgwin_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_be = 0;
  logic [63:0] reg_wdata = 0, probe_addr = 0;
  logic [63:0] reg_rdata, win_base, win_size, hole_start, hole_end;
  logic        win_en, hit, len_err;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  cfgwin_decoder u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .probe_addr(probe_addr),
    .win_en(win_en), .win_base(win_base), .win_size(win_size), .hit(hit),
    .len_err(len_err), .hole_start(hole_start), .hole_end(hole_end));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] be, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_be = 0;
  endtask

  task automatic probe(input string req, input logic [63:0] a, input logic exp);
    probe_addr = a; #1;
    chk(req, {63'd0, hit}, {63'd0, exp});
  endtask

  task automatic check_win(input string req, input logic en, input logic [63:0] base,
                           input logic [63:0] size, input logic [63:0] hs);
    chk({req, " en"}, {63'd0, win_en}, {63'd0, en});
    if (en) chk({req, " base"}, win_base, base);
    chk({req, " size"}, win_size, size);
    chk({req, " hole_start R8"}, hole_start, hs);
    chk("R9 hole_end", hole_end, 64'hFEBF_FFFF);
  endtask

  task automatic t_reset;
    chk("R1 rdata", reg_rdata, 64'hB000_0000);
    chk("R1 en", {63'd0, win_en}, 0);
    chk("R1 err", {63'd0, len_err}, 0);
    chk("R1 hole_start", hole_start, 64'hB000_0000);
    probe("R1 hit", 64'hB000_0000, 0);
  endtask

  task automatic t_256;
    wr(8'hFF, 64'hE000_0001);
    check_win("R3 256", 1, 64'hE000_0000, 64'h1000_0000, 64'hF000_0000);
    probe("R5 lo", 64'hE000_0000, 1);
    probe("R5 top", 64'hEFFF_FFFF, 1);
    probe("R5 above", 64'hF000_0000, 0);
    probe("R5 below", 64'hDFFF_FFFF, 0);
    wr(8'hFF, 64'hC400_0001);
    chk("R4 256 mask", win_base, 64'hC000_0000);
  endtask

  task automatic t_128;
    wr(8'hFF, 64'hFF00_0000_C87F_FFF3);
    chk("R2 readback", reg_rdata, 64'hFF00_0000_C87F_FFF3);
    check_win("R4 128", 1, 64'hC800_0000, 64'h0800_0000, 64'hD000_0000);
    probe("R5 128 top", 64'hCFFF_FFFF, 1);
    probe("R5 128 out", 64'hD000_0000, 0);
    wr(8'hFF, 64'hC400_0003);
    chk("R4 128 drop b26", win_base, 64'hC000_0000);
  endtask

  task automatic t_64;
    wr(8'hFF, 64'hC400_0005);
    check_win("R4 64", 1, 64'hC400_0000, 64'h0400_0000, 64'hC800_0000);
    probe("R5 64 in", 64'hC7FF_FFFF, 1);
    probe("R5 64 out", 64'hC800_0000, 0);
  endtask

  task automatic t_disabled;
    wr(8'hFF, 64'hE000_0000);
    check_win("R6 off", 0, 0, 64'h1000_0000, 64'hB000_0000);
    probe("R6 nohit", 64'hE000_0000, 0);
  endtask

  task automatic t_reserved;
    wr(8'hFF, 64'hE000_0007);
    chk("R7 err", {63'd0, len_err}, 1);
    check_win("R7 rsvd", 0, 0, 0, 64'hB000_0000);
    probe("R7 nohit", 64'hE000_0000, 0);
  endtask

  task automatic t_bytes;
    wr(8'h01, 64'hFFFF_FFFF_FFFF_FF01);
    chk("R2 be01", reg_rdata, 64'hE000_0001);
    chk("R2 err clr", {63'd0, len_err}, 0);
    wr(8'h08, 64'h0000_0000_D000_0000);
    chk("R2 be08", reg_rdata, 64'hD000_0001);
    chk("R2 base", win_base, 64'hD000_0000);
  endtask

  task automatic t_timing;
    @(negedge clk);
    reg_wr = 1; reg_be = 8'hFF; reg_wdata = 64'hA000_0001;
    #1 chk("R10 before edge", reg_rdata, 64'hD000_0001);
    chk("R10 base before", win_base, 64'hD000_0000);
    @(posedge clk); #1;
    reg_wr = 0; reg_be = 0;
    chk("R10 after edge", win_base, 64'hA000_0000);
    chk("R10 hole after", hole_start, 64'hB000_0000);
  endtask

  initial begin
    #3000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_256;
    t_128;
    t_64;
    t_disabled;
    t_reserved;
    t_bytes;
    t_timing;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule